// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the integer execute stage for data-processing operations. Each cycle it takes an operation code, a first operand, a second operand that an upstream shifter has already produced, and the carry that shifter pushed out. From these it forms a result with no clock in between. It also reports whether the result goes to a destination register and what the four condition flags (negative, zero, carry, overflow) would become.

One adder serves every arithmetic operation. Subtraction and reverse subtraction invert one of the operands, and a select chooses the adder's carry-in: zero, one, or the stored carry flag. Logical operations take their carry from the shifter and keep the stored overflow. Compare and test operations update only the flags.

The flags live in a four-bit register. The register loads only when the caller asks for flag updates on a defined operation. It is presented as the top nibble of a status word whose lower bits pass through untouched.

Top module: `flagAlu`

## Requirements
- R1: `statusOut` carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28, all from the flag register. Bits 27..0 equal `statusLow` at all times.
- R2: For every defined opcode, `flagsNext` is packed as {N,Z,C,V}. N equals bit 31 of the computed result, and Z is 1 exactly when all 32 result bits are zero.
- R3: ADD (opcode 4) and CMN (opcode 11) compute A+B. C is the unsigned carry out of bit 31, and V is set when the two's-complement sum overflows.
- R4: SUB (2) and CMP (10) compute A-B, and RSB (3) computes B-A. C is 1 when no borrow occurs, that is, when the minuend is greater than or equal to the subtrahend taken as unsigned values. V flags signed overflow.
- R5: ADC (5) computes A+B+C. SBC (6) computes A-B-(1-C), and RSC (7) computes B-A-(1-C). Here C is the stored carry flag. The carry and overflow rules are those of R3 and R4, with the extra term included.
- R6: The logical opcodes are AND 0, EOR 1, TST 8, TEQ 9, ORR 12, ORN 13, MOV 14, BIC 15, MVN 16 and top insert 17. They set C from `shiftCarry` and leave V at its stored value.
- R7: TST, TEQ, CMP and CMN drive `writeDest` low. Every other defined opcode (0..17) drives it high.
- R8: Top insert (17) returns operand B bits 15..0 in result bits 31..16 and operand A bits 15..0 in result bits 15..0.
- R9: The bitwise results are as follows: AND/TST give A&B, EOR/TEQ give A^B, ORR gives A|B, ORN gives A|~B, BIC gives A&~B, MOV gives B and MVN gives ~B.
- R10: At a rising clock edge the flag register loads `flagsNext` when `setFlags` is 1 and the opcode is defined. Otherwise it holds.
- R11: A synchronous reset clears all four flags at the next rising edge.
- R12: Opcodes 18..31 are undefined. They give result 0 and `writeDest` 0, and they leave the flags unchanged even with `setFlags` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 5 | Operation select |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Shifted second operand |
| shiftCarry | input | 1 | Carry out of the shifter |
| setFlags | input | 1 | Update the flags with this operation |
| statusLow | input | 28 | Lower status bits passed through |
| result | output | 32 | Operation result |
| writeDest | output | 1 | Result is to be written to a destination |
| flagsNext | output | 4 | Flags {N,Z,C,V} this operation produces |
| statusOut | output | 32 | Stored flags above the pass-through bits |

## Verification
`result`, `writeDest` and `flagsNext` are combinational and are due in the same cycle the inputs change. The bench drives inputs on the falling edge and samples these outputs a few nanoseconds later, before the next rising edge. The flag nibble of `statusOut` is due one rising edge after an operation with `setFlags` high, so the bench samples it just after that edge. The bench's reference flags advance at that same point, which means the stored carry and overflow used by the next operation match what the design holds.

// File: rtl/flagAluPkg.sv
package flagAluPkg;

  localparam int OP_BITS = 5;
  localparam int OP_LAST = 17;

  // flag nibble positions: {N,Z,C,V}
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [OP_BITS-1:0] {
    OP_AND = 5'd0,  OP_EOR = 5'd1,  OP_SUB = 5'd2,  OP_RSB = 5'd3,
    OP_ADD = 5'd4,  OP_ADC = 5'd5,  OP_SBC = 5'd6,  OP_RSC = 5'd7,
    OP_TST = 5'd8,  OP_TEQ = 5'd9,  OP_CMP = 5'd10, OP_CMN = 5'd11,
    OP_ORR = 5'd12, OP_ORN = 5'd13, OP_MOV = 5'd14, OP_BIC = 5'd15,
    OP_MVN = 5'd16, OP_INS = 5'd17
  } aluOp_t;

  typedef enum logic [2:0] {
    UNIT_NONE, UNIT_AND, UNIT_EOR, UNIT_ORR, UNIT_ADD, UNIT_MOV, UNIT_INS
  } unitSel_t;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } cinSel_t;

  typedef struct packed {
    unitSel_t unit;
    logic     invA;
    logic     invB;
    cinSel_t  cinSel;
    logic     arith;
    logic     writeEn;
    logic     flagEn;
  } aluCtrl_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import flagAluPkg::*;
(
  input  logic [OP_BITS-1:0] opcode,
  input  logic               setFlags,
  output aluCtrl_t           ctrl
);

  always_comb begin
    ctrl.unit    = UNIT_NONE;
    ctrl.invA    = 1'b0;
    ctrl.invB    = 1'b0;
    ctrl.cinSel  = CIN_ZERO;
    ctrl.arith   = 1'b0;
    ctrl.writeEn = 1'b1;
    unique case (aluOp_t'(opcode))
      OP_AND: ctrl.unit = UNIT_AND;
      OP_TST: begin ctrl.unit = UNIT_AND; ctrl.writeEn = 1'b0; end
      OP_BIC: begin ctrl.unit = UNIT_AND; ctrl.invB = 1'b1; end
      OP_EOR: ctrl.unit = UNIT_EOR;
      OP_TEQ: begin ctrl.unit = UNIT_EOR; ctrl.writeEn = 1'b0; end
      OP_ORR: ctrl.unit = UNIT_ORR;
      OP_ORN: begin ctrl.unit = UNIT_ORR; ctrl.invB = 1'b1; end
      OP_MOV: ctrl.unit = UNIT_MOV;
      OP_MVN: begin ctrl.unit = UNIT_MOV; ctrl.invB = 1'b1; end
      OP_INS: ctrl.unit = UNIT_INS;
      OP_ADD: begin ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; end
      OP_CMN: begin ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.writeEn = 1'b0; end
      OP_ADC: begin ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.cinSel = CIN_FLAG; end
      OP_SUB: begin
        ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE;
      end
      OP_CMP: begin
        ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_ONE;
        ctrl.writeEn = 1'b0;
      end
      OP_SBC: begin
        ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.invB = 1'b1; ctrl.cinSel = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.invA = 1'b1; ctrl.cinSel = CIN_ONE;
      end
      OP_RSC: begin
        ctrl.unit = UNIT_ADD; ctrl.arith = 1'b1; ctrl.invA = 1'b1; ctrl.cinSel = CIN_FLAG;
      end
      default: ctrl.writeEn = 1'b0;
    endcase
    ctrl.flagEn = setFlags && (ctrl.unit != UNIT_NONE);
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import flagAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  input  logic             shiftCarry,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flagsNext,
  output logic [3:0]       flagsQ
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] addX, addY, sum;
  logic [WIDTH:0]   wideSum;
  logic             carryIn, carryOut, overflow;
  logic [WIDTH-1:0] bSel;

  always_comb begin
    addX = ctrl.invA ? ~operandA : operandA;
    bSel = ctrl.invB ? ~operandB : operandB;
    addY = bSel;
    unique case (ctrl.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flagsQ[FLAG_C];
      default:  carryIn = 1'b0;
    endcase
    wideSum  = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, carryIn};
    sum      = wideSum[WIDTH-1:0];
    carryOut = wideSum[WIDTH];
    overflow = (addX[WIDTH-1] == addY[WIDTH-1]) && (sum[WIDTH-1] != addX[WIDTH-1]);
  end

  always_comb begin
    unique case (ctrl.unit)
      UNIT_AND: result = operandA & bSel;
      UNIT_EOR: result = operandA ^ bSel;
      UNIT_ORR: result = operandA | bSel;
      UNIT_ADD: result = sum;
      UNIT_MOV: result = bSel;
      UNIT_INS: result = {operandB[HALF-1:0], operandA[HALF-1:0]};
      default:  result = '0;
    endcase
  end

  always_comb begin
    if (ctrl.unit == UNIT_NONE) begin
      flagsNext = flagsQ;
    end else begin
      flagsNext[FLAG_N] = result[WIDTH-1];
      flagsNext[FLAG_Z] = (result == '0);
      flagsNext[FLAG_C] = ctrl.arith ? carryOut : shiftCarry;
      flagsNext[FLAG_V] = ctrl.arith ? overflow : flagsQ[FLAG_V];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              flagsQ <= '0;
    else if (ctrl.flagEn) flagsQ <= flagsNext;
  end

  // R11: reset clears the flags
  p_reset_clear_r11: assert property (@(posedge clk) rst |=> flagsQ == 4'b0000);

  // R10: load on enable, hold otherwise
  p_flag_load_r10: assert property (@(posedge clk) disable iff (rst)
    ctrl.flagEn |=> flagsQ == $past(flagsNext));
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !ctrl.flagEn |=> $stable(flagsQ));

  // R6: logical operations keep the stored overflow
  p_logic_keep_v_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl.unit != UNIT_NONE && !ctrl.arith) |-> flagsNext[FLAG_V] == flagsQ[FLAG_V]);

endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import flagAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_BITS-1:0] opcode,
  input  logic [WIDTH-1:0]   operandA,
  input  logic [WIDTH-1:0]   operandB,
  input  logic               shiftCarry,
  input  logic               setFlags,
  input  logic [WIDTH-5:0]   statusLow,
  output logic [WIDTH-1:0]   result,
  output logic               writeDest,
  output logic [3:0]         flagsNext,
  output logic [WIDTH-1:0]   statusOut
);

  localparam int HALF = WIDTH / 2;

  aluCtrl_t   ctrl;
  logic [3:0] flagsQ;

  aluControl uCtrl (
    .opcode   (opcode),
    .setFlags (setFlags),
    .ctrl     (ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH)) uPath (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .operandA   (operandA),
    .operandB   (operandB),
    .shiftCarry (shiftCarry),
    .result     (result),
    .flagsNext  (flagsNext),
    .flagsQ     (flagsQ)
  );

  assign writeDest = ctrl.writeEn;
  assign statusOut = {flagsQ, statusLow};

  // R12: undefined opcodes produce nothing
  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (opcode > OP_BITS'(OP_LAST)) |-> (!writeDest && result == '0));

  // R8: insert keeps the low half of operand A
  p_insert_low_r8: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_INS) |-> result[HALF-1:0] == operandA[HALF-1:0]);

  // R7: compare and test opcodes never write
  p_compare_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_TST || opcode == OP_TEQ || opcode == OP_CMP || opcode == OP_CMN)
      |-> !writeDest);

endmodule

// File: tb/flagAlu_test.sv
module flagAlu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  opcode = '0;
  logic [31:0] operandA = '0, operandB = '0;
  logic        shiftCarry = 1'b0, setFlags = 1'b0;
  logic [27:0] statusLow = '0;
  logic [31:0] result, statusOut;
  logic        writeDest;
  logic [3:0]  flagsNext;

  int checks = 0;
  int failures = 0;
  logic [3:0] modelFlags = 4'b0000;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flagAlu uut (
    .clk(clk), .rst(rst), .opcode(opcode), .operandA(operandA), .operandB(operandB),
    .shiftCarry(shiftCarry), .setFlags(setFlags), .statusLow(statusLow),
    .result(result), .writeDest(writeDest), .flagsNext(flagsNext), .statusOut(statusOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // returns {write, flags[3:0], result[31:0]}
  function automatic logic [36:0] refModel(input logic [4:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic sc,
                                           input logic [3:0] fl);
    logic [31:0] r = '0;
    logic w = 1'b1, c = sc, v = fl[0], arith = 1'b0, known = 1'b1;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint ua = longint'({32'd0, a});
    longint ub = longint'({32'd0, b});
    longint ci = fl[1] ? 64'sd1 : 64'sd0;
    longint sr = 0;
    logic [3:0] f;
    case (op)
      5'd0:  r = a & b;
      5'd1:  r = a ^ b;
      5'd8:  begin r = a & b; w = 1'b0; end
      5'd9:  begin r = a ^ b; w = 1'b0; end
      5'd12: r = a | b;
      5'd13: r = a | ~b;
      5'd14: r = b;
      5'd15: r = a & ~b;
      5'd16: r = ~b;
      5'd17: r = {b[15:0], a[15:0]};
      5'd4, 5'd11: begin arith = 1'b1; sr = sa + sb; c = (ua + ub) >= 64'sh1_0000_0000;
                         w = (op == 5'd4); end
      5'd5:  begin arith = 1'b1; sr = sa + sb + ci; c = (ua + ub + ci) >= 64'sh1_0000_0000; end
      5'd2, 5'd10: begin arith = 1'b1; sr = sa - sb; c = ua >= ub; w = (op == 5'd2); end
      5'd6:  begin arith = 1'b1; sr = sa - sb - (1 - ci); c = ua >= ub + 1 - ci; end
      5'd3:  begin arith = 1'b1; sr = sb - sa; c = ub >= ua; end
      5'd7:  begin arith = 1'b1; sr = sb - sa - (1 - ci); c = ub >= ua + 1 - ci; end
      default: begin known = 1'b0; w = 1'b0; end
    endcase
    if (arith) begin
      r = sr[31:0];
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end
    f = known ? {r[31], (r == 32'd0), c, v} : fl;
    return {w, f, r};
  endfunction

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd4, 5'd11:       return "R3";
      5'd2, 5'd3, 5'd10: return "R4";
      5'd5, 5'd6, 5'd7:  return "R5";
      5'd17:             return "R8";
      default:           return (op > 5'd17) ? "R12" : "R9";
    endcase
  endfunction

  task automatic applyOp(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic sf, input string flagTag);
    logic [36:0] exp;
    logic [27:0] low;
    @(negedge clk);
    low = 28'($urandom);
    opcode = op; operandA = a; operandB = b; shiftCarry = sc; setFlags = sf;
    statusLow = low;
    #3;
    exp = refModel(op, a, b, sc, modelFlags);
    check(reqOf(op), result, exp[31:0]);
    check("R7", {31'd0, writeDest}, {31'd0, exp[36]});
    check(flagTag, {28'd0, flagsNext}, {28'd0, exp[35:32]});
    if (sf && op <= 5'd17) modelFlags = exp[35:32];
    @(posedge clk);
    #2;
    check("R10", {28'd0, statusOut[31:28]}, {28'd0, modelFlags});
    check("R1", {4'd0, statusOut[27:0]}, {4'd0, low});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    check("R11", {28'd0, statusOut[31:28]}, 32'd0);

    // R3: signed overflow, and unsigned carry to zero
    applyOp(5'd4, 32'h7fff_ffff, 32'h0000_0001, 1'b0, 1'b1, "R3");
    applyOp(5'd4, 32'hffff_ffff, 32'h0000_0001, 1'b0, 1'b1, "R3");
    // R4: equal compare gives Z and C, no write
    applyOp(5'd10, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, "R4");
    applyOp(5'd2, 32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1, "R4");
    applyOp(5'd3, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1, "R4");
    applyOp(5'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, "R4");
    // R5: carry chained with C set then cleared
    applyOp(5'd4, 32'hffff_ffff, 32'h0000_0002, 1'b0, 1'b1, "R3");
    applyOp(5'd5, 32'h0000_0010, 32'h0000_0020, 1'b0, 1'b1, "R5");
    applyOp(5'd6, 32'h0000_0010, 32'h0000_0010, 1'b0, 1'b1, "R5");
    applyOp(5'd7, 32'h0000_0010, 32'h0000_0010, 1'b0, 1'b1, "R5");
    applyOp(5'd7, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, "R5");
    // R6: logical ops take shifter carry, keep V (V set first)
    applyOp(5'd4, 32'h7fff_ffff, 32'h0000_0001, 1'b0, 1'b1, "R3");
    applyOp(5'd8, 32'hf0f0_0000, 32'h0f0f_0000, 1'b1, 1'b1, "R6");
    applyOp(5'd9, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1, "R6");
    applyOp(5'd13, 32'h0000_00ff, 32'hffff_0000, 1'b1, 1'b1, "R6");
    applyOp(5'd15, 32'hffff_ffff, 32'h0000_ffff, 1'b0, 1'b1, "R6");
    applyOp(5'd16, 32'h0, 32'hffff_ffff, 1'b1, 1'b1, "R6");
    applyOp(5'd17, 32'hdead_beef, 32'h1234_5678, 1'b0, 1'b1, "R6");
    // R10: setFlags low holds the flags
    applyOp(5'd2, 32'h0, 32'h1, 1'b0, 1'b0, "R2");
    // R12: undefined opcode with setFlags high
    applyOp(5'd18, 32'hffff_ffff, 32'h1, 1'b1, 1'b1, "R12");
    applyOp(5'd31, 32'h0, 32'h0, 1'b1, 1'b1, "R12");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      logic [31:0] a, b;
      op = (i % 10 == 9) ? 5'(18 + ($urandom % 14)) : 5'($urandom % 18);
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 32'h8000_0000;
      applyOp(op, a, b, 1'($urandom), 1'($urandom), "R2");
    end

    // R11: reset mid-run clears flags
    applyOp(5'd2, 32'h0, 32'h1, 1'b0, 1'b1, "R4");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R11", {28'd0, statusOut[31:28]}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    modelFlags = 4'b0000;
    applyOp(5'd14, 32'h0, 32'h8000_0000, 1'b1, 1'b1, "R6");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule